// File: doc/BRIEF.md
# Double-Buffered Output Gamma Lookup Engine

This block applies a per-channel transfer curve to a three-channel pixel stream. Each channel (red, green, blue) has its own table of uniformly spaced curve points. The output is the linear interpolation between the two points that bracket the input value. There are two complete table sets, bank A and bank B. Pixels read from the bank that is currently active. Host software fills the other bank through a small register port and then requests a swap. The swap and any mode change take effect only on a frame-start pulse, so a single frame never mixes two curves.

The host port is a one-cycle write strobe with a 2-bit register address and a data word. Writing an index register sets a table pointer. Each data write then stores one point into every channel that the write mask enables, and advances the pointer. The mode and bank that are actually in use are driven out on dedicated read-back ports.

Top module: `gamma_lut_engine`

## Requirements
- R1: After reset the current mode and current bank read 0, `out_valid` is 0, the write mask is 3'b111, the host bank is A, the pointer is 0 and every table entry is 0.
- R2: Current mode 2 enables the lookup. Current modes 0, 1 and 3 are bypass, and in bypass `pix_out` equals the pixel presented one cycle earlier.
- R3: In lookup mode, current bank 0 maps pixels through bank A and current bank 1 maps them through bank B.
- R4: Writing register 0 (bits [1:0] requested mode, bit 2 requested bank) changes nothing visible. Only a `frame_start` pulse copies the requested values into `cur_mode`/`cur_bank`, and those outputs hold between pulses.
- R5: Register 1 bit 3 selects the bank that receives host writes (0 = A, 1 = B). Writes to the bank not in use leave the pixel output unchanged.
- R6: Register 1 bits [2:0] form a write mask: bit 2 red, bit 1 green, bit 0 blue. A data write updates only the channels whose bit is set.
- R7: Writing register 2 loads the pointer. Each write to register 3 stores its low DATA_W bits at the pointer and then increments the pointer.
- R8: Each channel table holds 2^SEG_BITS+1 entries. A data write while the pointer is at or beyond that count stores nothing, but the pointer still advances, wrapping modulo 2^ceil(log2(entries)).
- R9: With F = DATA_W-SEG_BITS, an input x gives k = x>>F and f = x mod 2^F, and the output is min(max, (E[k]*(2^F-f) + E[k+1]*f + 2^(F-1)) >> F).
- R10: Host writes into the bank currently used for pixels are accepted and affect the very next pixel.
- R11: `out_valid` is `pix_valid` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register: 0 mode/bank request, 1 mask/host bank, 2 pointer, 3 data |
| host_wdata | input | DATA_W | Host write data |
| frame_start | input | 1 | Frame boundary pulse that commits the requested mode and bank |
| pix_valid | input | 1 | Input pixel valid |
| pix_in | input | 3*DATA_W | Pixel {red, green, blue} |
| out_valid | output | 1 | Output pixel valid |
| pix_out | output | 3*DATA_W | Mapped pixel {red, green, blue} |
| cur_mode | output | 2 | Mode in use |
| cur_bank | output | 1 | Bank in use |

## Verification
The bench builds the engine with DATA_W = 8 and SEG_BITS = 3. That gives nine points per channel and a 5-bit interpolation weight, so every one of the 256 input codes can be swept on all three channels after each table change, mode change and bank swap. The small 4-bit pointer also lets the bench reach the dropped writes past the last entry and the pointer wrap-around in only a few host writes.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    localparam int NUM_CH = 3;
    localparam logic [1:0] MODE_LUT = 2'd2;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_CFG   = 2'd1,
        REG_INDEX = 2'd2,
        REG_DATA  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/gamma_host_regs.sv
module gamma_host_regs
    import gamma_lut_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int ENTRIES = 17,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              frame_start,
    output logic [1:0]        cur_mode,
    output logic              cur_bank,
    output logic              wr_en,
    output logic              wr_bank,
    output logic [2:0]        wr_mask,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [IDX_W:0] ENT_L = (IDX_W+1)'(ENTRIES);

    typedef struct packed {
        logic [1:0]       req_mode;
        logic             req_bank;
        logic [1:0]       cur_mode;
        logic             cur_bank;
        logic [2:0]       mask;
        logic             host_bank;
        logic [IDX_W-1:0] ptr;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (host_wr) begin
            case (reg_addr_e'(host_addr))
                REG_CTRL: begin
                    s_d.req_mode = host_wdata[1:0];
                    s_d.req_bank = host_wdata[2];
                end
                REG_CFG: begin
                    s_d.mask      = host_wdata[2:0];
                    s_d.host_bank = host_wdata[3];
                end
                REG_INDEX: s_d.ptr = host_wdata[IDX_W-1:0];
                REG_DATA:  s_d.ptr = s_q.ptr + 1'b1;
                default: ;
            endcase
        end
        if (frame_start) begin
            s_d.cur_mode = s_q.req_mode;
            s_d.cur_bank = s_q.req_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{req_mode: 2'd0, req_bank: 1'b0, cur_mode: 2'd0, cur_bank: 1'b0,
                     mask: 3'b111, host_bank: 1'b0, ptr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_mode = s_q.cur_mode;
    assign cur_bank = s_q.cur_bank;
    assign wr_en    = host_wr && (host_addr == REG_DATA) && ({1'b0, s_q.ptr} < ENT_L);
    assign wr_bank  = s_q.host_bank;
    assign wr_mask  = s_q.mask;
    assign wr_idx   = s_q.ptr;
    assign wr_data  = host_wdata;
endmodule

// File: rtl/gamma_lut_store.sv
module gamma_lut_store
    import gamma_lut_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int SEG_BITS = 4,
    parameter int ENTRIES  = 17,
    parameter int IDX_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_bank,
    input  logic [2:0]                   wr_mask,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_bank,
    input  logic [NUM_CH*SEG_BITS-1:0]   rd_seg,
    output logic [NUM_CH*DATA_W-1:0]     lo_flat,
    output logic [NUM_CH*DATA_W-1:0]     hi_flat
);
    logic [DATA_W-1:0] mem_d [2][NUM_CH][ENTRIES];
    logic [DATA_W-1:0] mem_q [2][NUM_CH][ENTRIES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_mask[c]) mem_d[wr_bank][c][wr_idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < NUM_CH; c++)
                    for (int e = 0; e < ENTRIES; e++)
                        mem_q[b][c][e] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
        logic [SEG_BITS-1:0] seg;
        logic [SEG_BITS:0]   nxt;
        assign seg = rd_seg[c*SEG_BITS +: SEG_BITS];
        assign nxt = {1'b0, seg} + 1'b1;
        assign lo_flat[c*DATA_W +: DATA_W] = mem_q[rd_bank][c][{1'b0, seg}];
        assign hi_flat[c*DATA_W +: DATA_W] = mem_q[rd_bank][c][nxt];
    end
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp #(
    parameter int DATA_W   = 10,
    parameter int SEG_BITS = 4
) (
    input  logic [DATA_W-1:0]          lo,
    input  logic [DATA_W-1:0]          hi,
    input  logic [DATA_W-SEG_BITS-1:0] frac,
    output logic [DATA_W-1:0]          y
);
    localparam int FRAC_W = DATA_W - SEG_BITS;
    localparam int AW     = DATA_W + FRAC_W + 2;
    localparam logic [AW-1:0] ONE  = AW'(1) << FRAC_W;
    localparam logic [AW-1:0] HALF = AW'(1) << (FRAC_W - 1);
    localparam logic [AW-1:0] MAXV = (AW'(1) << DATA_W) - AW'(1);

    logic [AW-1:0] w_hi, w_lo, acc, shifted;

    always_comb begin
        w_hi    = AW'(frac);
        w_lo    = ONE - w_hi;
        acc     = AW'(lo) * w_lo + AW'(hi) * w_hi + HALF;
        shifted = acc >> FRAC_W;
        y       = (shifted > MAXV) ? MAXV[DATA_W-1:0] : shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/gamma_lut_engine.sv
module gamma_lut_engine
    import gamma_lut_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int SEG_BITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [1:0]               host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    input  logic                     frame_start,
    input  logic                     pix_valid,
    input  logic [NUM_CH*DATA_W-1:0] pix_in,
    output logic                     out_valid,
    output logic [NUM_CH*DATA_W-1:0] pix_out,
    output logic [1:0]               cur_mode,
    output logic                     cur_bank
);
    localparam int FRAC_W  = DATA_W - SEG_BITS;
    localparam int ENTRIES = (1 << SEG_BITS) + 1;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef struct packed {
        logic                     valid;
        logic [NUM_CH*DATA_W-1:0] data;
    } out_t;

    logic                     wr_en, wr_bank;
    logic [2:0]               wr_mask;
    logic [IDX_W-1:0]         wr_idx;
    logic [DATA_W-1:0]        wr_data;
    logic [NUM_CH*SEG_BITS-1:0] seg_flat;
    logic [NUM_CH*DATA_W-1:0] lo_flat, hi_flat, lut_flat;
    out_t out_d, out_q;

    gamma_host_regs #(.DATA_W(DATA_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .frame_start(frame_start),
        .cur_mode(cur_mode), .cur_bank(cur_bank), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_mask(wr_mask), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    gamma_lut_store #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_mask(wr_mask),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_bank(cur_bank), .rd_seg(seg_flat),
        .lo_flat(lo_flat), .hi_flat(hi_flat)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign seg_flat[c*SEG_BITS +: SEG_BITS] = pix_in[c*DATA_W + FRAC_W +: SEG_BITS];
        gamma_interp #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) interp_i (
            .lo(lo_flat[c*DATA_W +: DATA_W]),
            .hi(hi_flat[c*DATA_W +: DATA_W]),
            .frac(pix_in[c*DATA_W +: FRAC_W]),
            .y(lut_flat[c*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        out_d.valid = pix_valid;
        out_d.data  = (cur_mode == MODE_LUT) ? lut_flat : pix_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign pix_out   = out_q.data;
endmodule

// File: rtl/gamma_lut_engine_chk.sv
module gamma_lut_engine_chk
    import gamma_lut_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int SEG_BITS = 4,
    parameter int IDX_W    = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     host_wr,
    input logic [1:0]               host_addr,
    input logic [DATA_W-1:0]        host_wdata,
    input logic                     frame_start,
    input logic                     pix_valid,
    input logic [NUM_CH*DATA_W-1:0] pix_in,
    input logic                     out_valid,
    input logic [NUM_CH*DATA_W-1:0] pix_out,
    input logic [1:0]               cur_mode,
    input logic                     cur_bank,
    input logic [IDX_W-1:0]         wr_idx
);
    a_r4_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(cur_mode) && $stable(cur_bank)));

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    a_r2_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cur_mode != MODE_LUT) |=> (pix_out == $past(pix_in)));

    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_DATA) |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1)));

    a_r7_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_INDEX) |=> (wr_idx == $past(host_wdata[IDX_W-1:0])));

    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(wr_idx));
endmodule

bind gamma_lut_engine gamma_lut_engine_chk #(
    .DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out),
    .cur_mode(cur_mode), .cur_bank(cur_bank), .wr_idx(wr_idx)
);

// File: tb/gamma_lut_engine_tb_top.sv
`timescale 1ns/1ps
module gamma_lut_engine_tb_top;
    localparam int DW  = 8;
    localparam int SB  = 3;
    localparam int F   = DW - SB;
    localparam int ENT = (1 << SB) + 1;
    localparam int PW  = 1 << $clog2(ENT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0;
    logic [1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic frame_start = 1'b0;
    logic pix_valid = 1'b0;
    logic [3*DW-1:0] pix_in = '0;
    logic out_valid;
    logic [3*DW-1:0] pix_out;
    logic [1:0] cur_mode;
    logic cur_bank;

    int nchk = 0;
    int nerr = 0;
    int mdl [2][3][ENT];
    int m_mask = 7, m_hb = 0, m_ptr = 0;
    int m_rmode = 0, m_rbank = 0, m_cmode = 0, m_cbank = 0;

    always #4 clk = ~clk;

    gamma_lut_engine #(.DATA_W(DW), .SEG_BITS(SB)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out),
        .cur_mode(cur_mode), .cur_bank(cur_bank)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input int a, input int d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 2'(a); host_wdata = DW'(d);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic set_cfg(input int mask, input int hb);
        hw(1, (hb << 3) | mask);
        m_mask = mask; m_hb = hb;
    endtask

    task automatic set_idx(input int i);
        hw(2, i);
        m_ptr = i % PW;
    endtask

    task automatic put(input int d);
        hw(3, d);
        if (m_ptr < ENT)
            for (int c = 0; c < 3; c++)
                if (m_mask[c]) mdl[m_hb][c][m_ptr] = d;
        m_ptr = (m_ptr + 1) % PW;
    endtask

    task automatic req(input int mode, input int bank);
        hw(0, (bank << 2) | mode);
        m_rmode = mode; m_rbank = bank;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_cmode = m_rmode; m_cbank = m_rbank;
    endtask

    function automatic int expect_ch(input int c, input int x);
        int k, f, acc, r;
        if (m_cmode != 2) return x;
        k = x >> F;
        f = x % (1 << F);
        acc = mdl[m_cbank][c][k] * ((1 << F) - f) + mdl[m_cbank][c][k+1] * f + (1 << (F-1));
        r = acc >> F;
        return (r > 255) ? 255 : r;
    endfunction

    task automatic sweep(input string tag);
        for (int v = 0; v < 256; v++) begin
            int xr, xg, xb, ex;
            xr = v; xg = v ^ 8'h5a; xb = 255 - v;
            @(negedge clk);
            pix_valid = 1'b1;
            pix_in = {8'(xr), 8'(xg), 8'(xb)};
            @(posedge clk);
            #2;
            ex = (expect_ch(2, xr) << 16) | (expect_ch(1, xg) << 8) | expect_ch(0, xb);
            check(tag, int'(pix_out), ex);
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 3; c++)
                for (int e = 0; e < ENT; e++) mdl[b][c][e] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cur_mode", int'(cur_mode), 0);
        check("R1 cur_bank", int'(cur_bank), 0);
        check("R1 out_valid", int'(out_valid), 0);

        sweep("R2 bypass mode 0");

        // Bank A through all three channels at once, starting from pointer 0
        for (int i = 0; i < ENT; i++) put((i * i * 255) / 64);
        // Bank B one channel at a time
        set_cfg(4, 1); set_idx(0);
        for (int i = 0; i < ENT; i++) put(255 - i * 31);
        set_cfg(2, 1); set_idx(0);
        for (int i = 0; i < ENT; i++) put(i * 30 + 10);
        set_cfg(1, 1); set_idx(0);
        for (int i = 0; i < ENT; i++) put(128);

        req(2, 0);
        check("R4 mode held before frame", int'(cur_mode), 0);
        sweep("R4 still bypass before frame");
        frame();
        @(negedge clk);
        check("R4 mode after frame", int'(cur_mode), 2);
        check("R4 bank after frame", int'(cur_bank), 0);
        sweep("R9 R3 bank A interpolation");

        req(2, 1);
        frame();
        @(negedge clk);
        check("R3 bank B selected", int'(cur_bank), 1);
        sweep("R3 R6 bank B per-channel tables");

        set_cfg(3, 1); set_idx(2);
        put(200); put(201); put(202);
        sweep("R10 R6 write into active bank B");

        set_cfg(7, 0); set_idx(8);
        put(250);
        put(77);
        set_idx(15);
        put(9);
        put(5);
        sweep("R5 inactive bank A writes hidden");
        req(2, 0);
        frame();
        sweep("R8 R7 bank A after range drop and wrap");

        req(1, 0);
        frame();
        @(negedge clk);
        check("R2 reserved mode readback", int'(cur_mode), 1);
        sweep("R2 reserved mode 1 bypass");
        req(3, 1);
        frame();
        sweep("R2 reserved mode 3 bypass");

        @(negedge clk);
        pix_valid = 1'b1;
        @(negedge clk);
        check("R11 valid high", int'(out_valid), 1);
        pix_valid = 1'b0;
        @(negedge clk);
        check("R11 valid low", int'(out_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule